// File: doc/BRIEF.md
# Latched Protection Response Logic

This block stands beside a processor port as a small challenge-response device. The processor writes a byte into a holding register. A later read of the port returns an eight-bit answer. The answer is computed only from the low four bits of the stored value. The lower half of the answer repeats those four bits. Each bit of the upper half is a fixed Boolean function of them. Bits stored above the low nibble are kept in the register but play no part in the answer.

The read path is registered. A read strobe loads the answer for the current register contents into the read data output, one clock edge later. The output then holds that value until the next read strobe. If a write and a read arrive in the same cycle, the read answers for the value held before that write. Port decoding and the port controller itself sit outside this block.

Top module: `prot_resp_top`

## Requirements
- R1: On the clock edge where `wr_stb` is high, the whole `wr_data` word is stored in the holding register. Every later answer is computed from that stored value.
- R2: Answer bits 3..0 equal holding register bits 3..0.
- R3: Answer bit 4 is 1 exactly when holding register bits 3..0 are all zero.
- R4: Answer bit 5 is 1 exactly when (bit 2 or bit 3 is set) and (bit 0 or bit 1 is set), using holding register bits.
- R5: Answer bit 6 is 1 exactly when holding register bit 0 or bit 3 is set.
- R6: Answer bit 7 is 1 exactly when holding register bit 1 is set and bit 2 is clear.
- R7: A synchronous active-low reset clears the holding register and sets `rd_data` to 0x00. A read issued before any write therefore returns 0x10.
- R8: A read leaves the holding register unchanged, so back-to-back reads return the same answer. Between read strobes, `rd_data` keeps its value.
- R9: Holding register bits above bit 3 have no effect on the answer.
- R10: `rd_data` takes the new answer on the clock edge where `rd_stb` is high. When `wr_stb` is high in that same cycle, the answer is for the value held before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_stb | input | 1 | Write strobe, one cycle per write |
| wr_data | input | DATA_W | Value to store |
| rd_stb | input | 1 | Read strobe, one cycle per read |
| rd_data | output | 8 | Registered answer |

## Verification
The bench builds the block with DATA_W set to 12 instead of the default 8. This gives the holding register eight bits above the low nibble. Those extra bits can then carry many patterns, which makes the check of R9 stronger than a plain byte would allow. All sixteen low-nibble values are swept, each with several different upper patterns. The same-cycle write-and-read ordering and the hold of `rd_data` between reads are covered by their own scenarios.

// File: rtl/prot_resp_pkg.sv
// Package: shared width constants and the answer function.
// Assumes the challenge key is always the low four bits of the holding register.
package prot_resp_pkg;
    localparam int KEY_W = 4;
    localparam int ANS_W = 8;

    // Builds the eight-bit answer from a four-bit key.
    function automatic logic [ANS_W-1:0] answer_of(input logic [KEY_W-1:0] k);
        logic [ANS_W-1:0] a;
        a[3:0] = k;
        a[4]   = ~(|k);
        a[5]   = (k[2] | k[3]) & (k[0] | k[1]);
        a[6]   = k[0] | k[3];
        a[7]   = k[1] & ~k[2];
        return a;
    endfunction
endpackage

// File: rtl/prot_hold_reg.sv
// Holding register: stores the full write word on a write strobe.
// Assumes a synchronous active-low reset that clears it to zero.
module prot_hold_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] q
);
    // Capture the write word; reads never touch this register.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= din;
    end
endmodule

// File: rtl/prot_answer_fn.sv
// Answer function: combinational map from the key to the answer byte.
// Assumes the key has already been cut from the holding register.
module prot_answer_fn
    import prot_resp_pkg::*;
(
    input  logic [KEY_W-1:0] key,
    output logic [ANS_W-1:0] ans
);
    // Evaluate the fixed answer equations.
    always_comb ans = answer_of(key);
endmodule

// File: rtl/prot_resp_top.sv
// Top: holding register, answer function and registered read port.
// Assumes DATA_W >= 4; only the low four stored bits form the key.
module prot_resp_top
    import prot_resp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_stb,
    output logic [7:0]        rd_data
);
    logic [DATA_W-1:0] latch_q;
    logic [ANS_W-1:0]  ans_now;

    prot_hold_reg #(.DATA_W(DATA_W)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (wr_stb),
        .din   (wr_data),
        .q     (latch_q)
    );

    prot_answer_fn u_fn (
        .key (latch_q[KEY_W-1:0]),
        .ans (ans_now)
    );

    // Load the answer on a read strobe and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_data <= '0;
        else if (rd_stb) rd_data <= ans_now;
    end
endmodule

// File: rtl/prot_resp_chk.sv
// Checker: temporal properties of the protection block, bound to the top.
module prot_resp_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_stb,
    input logic [DATA_W-1:0] wr_data,
    input logic              rd_stb,
    input logic [7:0]        rd_data,
    input logic [DATA_W-1:0] latch_q
);
    AST_WR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> latch_q == $past(wr_data)); // R1
    AST_LOW_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> rd_data[3:0] == $past(latch_q[3:0])); // R2
    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> rd_data[4] == ($past(latch_q[3:0]) == 4'd0)); // R3
    AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[4] |-> rd_data[3:0] == 4'd0); // R3
    AST_BIT6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> rd_data[6] == ($past(latch_q[0]) | $past(latch_q[3]))); // R5
    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(latch_q)); // R8
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(rd_data)); // R8
endmodule

bind prot_resp_top prot_resp_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_stb  (wr_stb),
    .wr_data (wr_data),
    .rd_stb  (rd_stb),
    .rd_data (rd_data),
    .latch_q (latch_q)
);

// File: tb/prot_resp_top_bench.sv
module prot_resp_top_bench;
    localparam int DW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_stb = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_stb = 1'b0;
    logic [7:0]    rd_data;
    int            n_run = 0;
    int            n_bad = 0;

    always #5 clk = ~clk;

    prot_resp_top #(.DATA_W(DW)) u_prot_resp_top (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
        .rd_stb(rd_stb), .rd_data(rd_data)
    );

    // Reference answer, written independently from the requirement text.
    function automatic logic [7:0] ref_ans(input logic [DW-1:0] v);
        logic [3:0] k;
        logic [7:0] r;
        k = v[3:0];
        r = {4'b0, k};
        if (k == 4'd0) r[4] = 1'b1;
        if ((k >> 2) != 0 && (k & 4'd3) != 0) r[5] = 1'b1;
        if ((k & 4'b1001) != 0) r[6] = 1'b1;
        if (k[2:1] == 2'b01) r[7] = 1'b1;
        return r;
    endfunction

    task automatic check(input string req, input logic [7:0] exp);
        n_run++;
        if (rd_data !== exp) begin
            n_bad++;
            $display("FAIL %s: rd_data=%02h expected=%02h", req, rd_data, exp);
        end
    endtask

    task automatic do_write(input logic [DW-1:0] v);
        @(negedge clk); wr_stb = 1'b1; wr_data = v;
        @(negedge clk); wr_stb = 1'b0;
    endtask

    task automatic do_read;
        @(negedge clk); rd_stb = 1'b1;
        @(negedge clk); rd_stb = 1'b0;
    endtask

    // R7: reset values and the first read before any write.
    task automatic t_reset;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check("R7 reset", 8'h00);
        do_read();
        check("R7 first read", 8'h10);
    endtask

    // R1..R6: sweep all keys with a clear upper part.
    task automatic t_sweep;
        for (int k = 0; k < 16; k++) begin
            do_write(DW'(k));
            do_read();
            check("R1-sweep R2 R3 R4 R5 R6", ref_ans(DW'(k)));
        end
    endtask

    // R9: same key, varied upper bits, must give the same answer.
    task automatic t_upper;
        for (int k = 0; k < 16; k++) begin
            for (int u = 1; u < 4; u++) begin
                logic [DW-1:0] v;
                v = DW'((((k * 37 + u * 91) & 8'hff) << 4) | k);
                do_write(v);
                do_read();
                check("R9 upper ignored", ref_ans(DW'(k)));
            end
        end
    endtask

    // R8: repeated reads agree; the output holds between reads.
    task automatic t_repeat;
        do_write(DW'(12'h5a6));
        do_read();
        check("R8 first read", ref_ans(DW'(12'h5a6)));
        repeat (3) @(negedge clk);
        check("R8 hold between reads", ref_ans(DW'(12'h5a6)));
        do_read();
        check("R8 second read", ref_ans(DW'(12'h5a6)));
        do_write(DW'(12'h003));
        check("R8 write alone leaves rd_data", ref_ans(DW'(12'h5a6)));
    endtask

    // R10: a read in the same cycle as a write answers for the old value.
    task automatic t_same_cycle;
        do_write(DW'(12'h002));
        @(negedge clk); wr_stb = 1'b1; wr_data = DW'(12'h00c); rd_stb = 1'b1;
        @(negedge clk); wr_stb = 1'b0; rd_stb = 1'b0;
        check("R10 old value", ref_ans(DW'(12'h002)));
        do_read();
        check("R10 new value", ref_ans(DW'(12'h00c)));
    endtask

    initial begin
        t_reset();
        t_sweep();
        t_upper();
        t_repeat();
        t_same_cycle();
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin
        #200000;
        n_run++;
        n_bad++;
        $display("FAIL watchdog: expired, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end
endmodule